// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the fetch address of a 32-bit load/store-style core and decides, one instruction at a time, where fetch goes next. Every accepted instruction word arrives together with the values of the two registers it names. If the word is an equal-compare or not-equal-compare branch whose condition holds, the block works out a PC-relative target. It lets exactly one more instruction, the delay slot, go through at the sequential address, and then jumps. Any other word advances the address by four.

Instructions come in on a valid/ready pair. A transfer happens on a rising clock edge when `instr_valid` and `instr_ready` are both high. `instr_ready` is simply the inverse of the plain `stall` control input. While no transfer happens, the address and any pending redirect keep their values. The producer must hold the word and operands steady until a transfer completes. `fetch_pc` is always the address of the word the block expects next.

Top module: `brsq_pc_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `fetch_pc` to the parameter `RESET_VEC` (default 0x00400000) and drops any pending redirect, so the first transfer after reset is sequential.
- R2: A transferred word whose opcode field (bits 31:26) is neither 6'b000100 nor 6'b000101 moves `fetch_pc` to `fetch_pc + 4`.
- R3: An equal-branch (opcode 6'b000100) whose operands `src_a` and `src_b` are identical is taken. The next `fetch_pc` is the branch address + 4 (the delay slot), and the transfer after that goes to the target.
- R4: An equal-branch whose operands differ is not taken, and fetch continues at +4 with no later redirect.
- R5: A not-equal-branch (opcode 6'b000101) is taken when the operands differ and not taken when they are identical.
- R6: The comparison looks at all 32 raw bits with no signed or unsigned meaning. 0xFFFFFFFF and 0x7FFFFFFF differ, and only identical patterns count as equal.
- R7: The target is the branch address + 4 + the sign-extended 16-bit offset (bits 15:0) times 4. Negative offsets give backward targets.
- R8: All address arithmetic wraps modulo 2^32.
- R9: A branch sitting in a delay slot is ignored. The earlier branch's target is used, and the address after that target is sequential.
- R10: While `stall` is high, `instr_ready` is low and `fetch_pc` and the pending redirect hold. Words offered during a stall have no effect.
- R11: While `instr_valid` is low, nothing advances and the offered word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold request; freezes all sequencing state |
| instr_valid | input | 1 | Instruction word and operands are offered |
| instr_ready | output | 1 | Block can accept a word (low during stall) |
| instr_word | input | 32 | Instruction at `fetch_pc`: opcode 31:26, register numbers 25:21 and 20:16, offset 15:0 |
| src_a | input | 32 | Value of the first named register |
| src_b | input | 32 | Value of the second named register |
| fetch_pc | output | 32 | Address of the next word to fetch |

## Verification
The hardest state to reach from the ports is a taken branch in the delay slot of another taken branch. There, the pending redirect and a fresh taken decision compete on the same edge. The stimulus sets up a taken equal-branch and then offers a not-equal-branch with differing operands and a different offset in the very next transfer. The test passes only if fetch lands on the first target and then steps by four. A second hard case is the pending redirect surviving back-pressure: stall and idle cycles are put between a taken branch and its delay slot. Wrap-around is reached with a second instance whose reset vector sits just below 2^32.

// File: rtl/brsq_pkg.sv
package brsq_pkg;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned OFF_W   = 16;
  localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BR_NE = 6'b000101;

  typedef enum logic [1:0] {
    BRK_NONE = 2'd0,
    BRK_EQ   = 2'd1,
    BRK_NE   = 2'd2
  } br_kind_e;

  function automatic br_kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_BR_EQ: classify = BRK_EQ;
      OPC_BR_NE: classify = BRK_NE;
      default:   classify = BRK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/brsq_decide.sv
module brsq_decide
  import brsq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  output logic             take
);
  logic [XLEN-1:0] bit_diff;
  logic            same;
  br_kind_e        kind;

  for (genvar i = 0; i < XLEN; i++) begin : g_cmp
    assign bit_diff[i] = src_a[i] ^ src_b[i];
  end

  assign same = ~|bit_diff;
  assign kind = classify(opcode);

  always_comb begin
    case (kind)
      BRK_EQ:  take = same;
      BRK_NE:  take = ~same;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/brsq_target.sv
module brsq_target
  import brsq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  base_pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  localparam int unsigned SHIFT = 2;
  localparam int unsigned EXT_W = XLEN - OFF_W - SHIFT;

  logic [XLEN-1:0] byte_off;

  assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
  assign target   = base_pc + byte_off;
endmodule

// File: rtl/brsq_redirect.sv
module brsq_redirect #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            take,
  input  logic [XLEN-1:0] tgt_in,
  output logic            pend_q,
  output logic [XLEN-1:0] tgt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (adv) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (take) begin
        pend_q <= 1'b1;
        tgt_q  <= tgt_in;
      end
    end
  end
endmodule

// File: rtl/brsq_pc_seq.sv
module brsq_pc_seq
  import brsq_pkg::*;
#(
  parameter int unsigned      XLEN      = 32,
  parameter logic [XLEN-1:0]  RESET_VEC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [XLEN-1:0] instr_word,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] fetch_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam int unsigned OPC_LSB = XLEN - OPC_W;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] tgt_q;
  logic            pend_q;
  logic            take;
  logic            adv;
  logic            regsel_unused;

  assign regsel_unused = ^instr_word[OPC_LSB-1:OFF_W];

  assign instr_ready = ~stall;
  assign adv         = instr_valid & instr_ready;
  assign seq_pc      = pc_q + STEP;

  brsq_decide #(.XLEN(XLEN)) u_decide (
    .opcode (instr_word[XLEN-1:OPC_LSB]),
    .src_a  (src_a),
    .src_b  (src_b),
    .take   (take)
  );

  brsq_target #(.XLEN(XLEN)) u_target (
    .base_pc (seq_pc),
    .offset  (instr_word[OFF_W-1:0]),
    .target  (br_tgt)
  );

  brsq_redirect #(.XLEN(XLEN)) u_redirect (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .take   (take),
    .tgt_in (br_tgt),
    .pend_q (pend_q),
    .tgt_q  (tgt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_VEC;
    end else if (adv) begin
      pc_q <= pend_q ? tgt_q : seq_pc;
    end
  end

  assign fetch_pc = pc_q;
endmodule

// File: rtl/brsq_pc_seq_chk.sv
module brsq_pc_seq_chk #(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            instr_valid,
  input logic            instr_ready,
  input logic [5:0]      opcode,
  input logic [15:0]     offset,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] fetch_pc,
  input logic            pend,
  input logic [XLEN-1:0] tgt
);
  logic            fire;
  logic            cond;
  logic [XLEN-1:0] exp_tgt;

  assign fire    = instr_valid && instr_ready;
  assign cond    = ((opcode == 6'b000100) && (src_a == src_b)) ||
                   ((opcode == 6'b000101) && (src_a != src_b));
  assign exp_tgt = fetch_pc + XLEN'(4) + (XLEN'(signed'(offset)) << 2);

  assert_reset_vec_R1: assert property (@(posedge clk)
    rst |=> (fetch_pc == RESET_VEC) && !pend);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && !pend && opcode != 6'b000100 && opcode != 6'b000101)
      |=> fetch_pc == $past(fetch_pc) + XLEN'(4));

  assert_taken_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && !pend && cond) |=> pend && fetch_pc == $past(fetch_pc) + XLEN'(4));

  // R5 and R6 share this check: the decision uses raw pattern compare.
  assert_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && !pend && !cond) |=> !pend && fetch_pc == $past(fetch_pc) + XLEN'(4));

  assert_target_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && !pend && cond) |=> tgt == $past(exp_tgt));

  assert_slot_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    (fire && pend) |=> !pend && fetch_pc == $past(tgt));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(fetch_pc) && $stable(pend) && $stable(tgt));

  assert_ready_R10: assert property (@(posedge clk) disable iff (rst)
    stall |-> !instr_ready);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(fetch_pc) && $stable(pend));
endmodule

bind brsq_pc_seq brsq_pc_seq_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall       (stall),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .opcode      (instr_word[31:26]),
  .offset      (instr_word[15:0]),
  .src_a       (src_a),
  .src_b       (src_b),
  .fetch_pc    (fetch_pc),
  .pend        (pend_q),
  .tgt         (tgt_q)
);

// File: tb/test_brsq_pc_seq.sv
`timescale 1ns/1ps
module test_brsq_pc_seq;
  localparam logic [31:0] NOP = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready, ready_hi;
  logic [31:0] instr_word = NOP;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] fetch_pc, pc_hi;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  brsq_pc_seq i_brsq_pc_seq (
    .clk(clk), .rst(rst), .stall(stall), .instr_valid(instr_valid),
    .instr_ready(instr_ready), .instr_word(instr_word),
    .src_a(src_a), .src_b(src_b), .fetch_pc(fetch_pc));

  brsq_pc_seq #(.RESET_VEC(32'hFFFF_FFF8)) i_brsq_pc_seq_hi (
    .clk(clk), .rst(rst), .stall(stall), .instr_valid(instr_valid),
    .instr_ready(ready_hi), .instr_word(instr_word),
    .src_a(src_a), .src_b(src_b), .fetch_pc(pc_hi));

  function automatic logic [31:0] mk_beq(input logic [15:0] off);
    return {6'b000100, 5'd0, 5'd9, off};
  endfunction
  function automatic logic [31:0] mk_bne(input logic [15:0] off);
    return {6'b000101, 5'd0, 5'd9, off};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    instr_word  = w;
    src_a       = a;
    src_b       = b;
    instr_valid = 1'b1;
    stall       = 1'b0;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; instr_valid = 1'b0; stall = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic to_0x10();
    for (int i = 0; i < 4; i++) issue(NOP, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset pc", fetch_pc, 32'h0040_0000);
    check("R1 ready", {31'd0, instr_ready}, 32'd1);
    issue(NOP, 0, 0);
    check("R1 no pending after reset", fetch_pc, 32'h0040_0004);
  endtask

  task automatic t_seq();
    do_reset();
    issue(NOP, 0, 0);
    issue(32'hAC00_1234, 5, 5);
    issue(32'h0000_0000, 1, 1);
    check("R2 sequential", fetch_pc, 32'h0040_000C);
  endtask

  task automatic t_beq_taken();
    do_reset(); to_0x10();
    issue(32'h1009_0003, 0, 0);
    check("R3 delay slot", fetch_pc, 32'h0040_0014);
    issue(NOP, 0, 0);
    check("R3 R7 target", fetch_pc, 32'h0040_0020);
    issue(NOP, 0, 0);
    check("R3 after target", fetch_pc, 32'h0040_0024);
  endtask

  task automatic t_beq_not();
    do_reset(); to_0x10();
    issue(mk_beq(16'h0003), 1, 2);
    issue(NOP, 0, 0);
    check("R4 not taken", fetch_pc, 32'h0040_0018);
  endtask

  task automatic t_bne();
    do_reset(); to_0x10();
    issue(mk_bne(16'h0003), 7, 8);
    issue(NOP, 0, 0);
    check("R5 bne taken", fetch_pc, 32'h0040_0020);
    issue(mk_bne(16'h0003), 9, 9);
    issue(NOP, 0, 0);
    check("R5 bne not taken", fetch_pc, 32'h0040_0028);
  endtask

  task automatic t_raw();
    do_reset(); to_0x10();
    issue(mk_beq(16'h0003), 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    issue(NOP, 0, 0);
    check("R6 beq raw differ", fetch_pc, 32'h0040_0018);
    issue(mk_bne(16'h0003), 32'h8000_0000, 32'h8000_0000);
    issue(NOP, 0, 0);
    check("R6 bne raw same", fetch_pc, 32'h0040_0020);
    issue(mk_bne(16'h0001), 32'h0000_0001, 32'h8000_0001);
    issue(NOP, 0, 0);
    check("R6 bne msb only", fetch_pc, 32'h0040_0028);
  endtask

  task automatic t_neg();
    do_reset(); to_0x10();
    issue(mk_beq(16'hFFFE), 3, 3);
    issue(NOP, 0, 0);
    check("R7 backward", fetch_pc, 32'h0040_000C);
  endtask

  task automatic t_wrap();
    do_reset();
    check("R8 hi reset", pc_hi, 32'hFFFF_FFF8);
    issue(mk_beq(16'h0001), 4, 4);
    check("R8 hi slot", pc_hi, 32'hFFFF_FFFC);
    issue(NOP, 0, 0);
    check("R8 wrapped target", pc_hi, 32'h0000_0000);
    issue(NOP, 0, 0);
    check("R8 after wrap", pc_hi, 32'h0000_0004);
  endtask

  task automatic t_slot_branch();
    do_reset(); to_0x10();
    issue(mk_beq(16'h0003), 0, 0);
    issue(mk_bne(16'h0010), 1, 2);
    check("R9 first target wins", fetch_pc, 32'h0040_0020);
    issue(NOP, 0, 0);
    check("R9 slot branch ignored", fetch_pc, 32'h0040_0024);
  endtask

  task automatic t_stall();
    do_reset(); to_0x10();
    issue(mk_beq(16'h0003), 0, 0);
    instr_word = NOP; instr_valid = 1'b1; stall = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 pc held", fetch_pc, 32'h0040_0014);
    check("R10 ready low", {31'd0, instr_ready}, 32'd0);
    issue(NOP, 0, 0);
    check("R10 pending kept", fetch_pc, 32'h0040_0020);
    instr_word = mk_beq(16'h0010); src_a = 0; src_b = 0;
    instr_valid = 1'b1; stall = 1'b1;
    repeat (2) @(negedge clk);
    issue(NOP, 0, 0);
    issue(NOP, 0, 0);
    check("R10 stalled branch no effect", fetch_pc, 32'h0040_0028);
  endtask

  task automatic t_idle();
    do_reset(); to_0x10();
    instr_word = mk_beq(16'h0008); src_a = 0; src_b = 0; instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 idle hold", fetch_pc, 32'h0040_0010);
    issue(NOP, 0, 0);
    issue(NOP, 0, 0);
    check("R11 idle branch no effect", fetch_pc, 32'h0040_0018);
    issue(mk_beq(16'h0002), 0, 0);
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    issue(NOP, 0, 0);
    check("R11 pending across idle", fetch_pc, 32'h0040_0024);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_seq();
    t_beq_taken();
    t_beq_not();
    t_bne();
    t_raw();
    t_neg();
    t_wrap();
    t_slot_branch();
    t_stall();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule